// File: doc/BRIEF.md
# Clock Gear and Standby Controller

This block selects the CPU clock for a small microcontroller and sequences its low-power modes. Everything runs on the main oscillator clock `clk`. The 32.768 kHz sub clock arrives as a one-cycle pulse `sub_tick` for each of its periods, together with a level that says whether the sub oscillator is running. The block does not produce gated clocks. It produces clock-enable strobes: the CPU advances on cycles where `cpu_clk_en` is high, and the peripherals advance on cycles where `per_clk_en` is high.

Software picks the CPU source with one write. The choices are the full main clock, a half-rate or quarter-rate gear of it, or the sub clock. The same write can ask to switch the main oscillator off, which is allowed only when the sub clock becomes the source. A standby strobe with a mode code puts the block into one of three levels:

- HALT stops only the CPU.
- Quick stop also stops the peripherals.
- Full stop also turns the main oscillator off.

Leaving full stop waits a programmable settling count. A pending interrupt or the non-maskable interrupt wakes the block from any level. Reset returns it to the undivided main clock.

Top module: `ckgear_standby`

## Requirements
- R1: The CPU source code is 00 for the main clock (an enable on every cycle), 01 for half rate (one enable per 2 cycles), 10 for quarter rate (one enable per 4 cycles) and 11 for the sub clock (one enable for each `sub_tick`). The active code is shown in status bits [4:3].
- R2: A source change is glitch-free. The new source takes over only in the cycle after the old source gave its last enable, or at once if the old source is not running. Status bit 7 is high while a switch is pending.
- R3: Standby mode code 01 (HALT) forces `cpu_clk_en` low. `per_clk_en` and `main_osc_en` keep running. Status bits [2:0] read 1.
- R4: Mode code 10 (quick stop) forces both clock enables low and keeps `main_osc_en` high. Status bits [2:0] read 2.
- R5: Mode code 11 (full stop) forces both clock enables low and also drives `main_osc_en` low. Status bits [2:0] read 3.
- R6: A wake event in HALT or quick stop returns the block to run (status bits [2:0] = 0) at the next clock edge, and CPU enables resume.
- R7: A wake event in full stop turns the oscillator on and holds a settling state (status bits [2:0] = 4) for `settle_val`+1 cycles with both clock enables low. The block then runs.
- R8: Either `irq_pend` or `nmi` is a wake event. A standby strobe with mode code 00, or any strobe outside run, has no effect.
- R9: Reset gives status 0x00: run state, main clock source, no flags. It also keeps `main_osc_en` and `per_clk_en` high. A reset during a gear setting restores the full main clock rate.
- R10: A write selecting the sub clock while `sub_osc_on` is low is ignored as a whole and sets status bit 5. Any accepted write clears bit 5.
- R11: A write with `cfg_main_off` set is accepted only when it also selects the sub clock. It then drives `main_osc_en` low, sets status bit 6 and makes `per_clk_en` follow `sub_tick`. With any other source the write is ignored as a whole and sets status bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sub_tick | input | 1 | One-cycle pulse per sub clock period |
| sub_osc_on | input | 1 | Sub oscillator running |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_src | input | 2 | Requested CPU source code |
| cfg_main_off | input | 1 | Request to stop the main oscillator |
| stby_req | input | 1 | Standby entry strobe |
| stby_mode | input | 2 | Standby level code for the strobe |
| irq_pend | input | 1 | An enabled interrupt is pending |
| nmi | input | 1 | Non-maskable interrupt |
| settle_val | input | 16 | Oscillator settling count for full stop exit |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| main_osc_en | output | 1 | Main oscillator enable |
| status | output | 8 | [2:0] power state, [4:3] active source, [5] refused write, [6] main oscillator off by software, [7] switch pending |

## Verification
The assertions rely on several properties of the inputs:
- `sub_tick` lasts one cycle and occurs only while `sub_osc_on` is high.
- `settle_val` stays constant while the block is settling.
- Strobes and wake inputs change only between clock edges.

The stimulus meets these conditions:
- It generates `sub_tick` every eighth cycle from a counter gated by `sub_osc_on`.
- It programs `settle_val` before entering full stop.
- It drives all inputs on the falling edge and pulses wake events for exactly one cycle.
- It lets each source switch complete before it counts enables over whole periods.

// File: rtl/ckg_pkg.sv
package ckg_pkg;
  typedef enum logic [1:0] {
    SRC_MAIN = 2'b00,
    SRC_DIV2 = 2'b01,
    SRC_DIV4 = 2'b10,
    SRC_SUB  = 2'b11
  } ckg_src_e;

  typedef enum logic [1:0] {
    MD_NONE  = 2'b00,
    MD_HALT  = 2'b01,
    MD_QSTOP = 2'b10,
    MD_STOP  = 2'b11
  } ckg_mode_e;

  typedef enum logic [2:0] {
    PS_RUN    = 3'd0,
    PS_HALT   = 3'd1,
    PS_QSTOP  = 3'd2,
    PS_STOP   = 3'd3,
    PS_SETTLE = 3'd4
  } ckg_pstate_e;
endpackage

// File: rtl/ckg_cfg.sv
module ckg_cfg
  import ckg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cfg_wr,
  input  ckg_src_e cfg_src,
  input  logic     cfg_main_off,
  input  logic     sub_osc_on,
  output ckg_src_e sel_src,
  output logic     main_sw_off,
  output logic     refused
);
  ckg_src_e sel_src_q, sel_src_d;
  logic     main_off_q, main_off_d;
  logic     refused_q, refused_d;
  logic     bad_wr;

  always_comb begin
    bad_wr     = ((cfg_src == SRC_SUB) && !sub_osc_on) ||
                 (cfg_main_off && (cfg_src != SRC_SUB));
    sel_src_d  = sel_src_q;
    main_off_d = main_off_q;
    refused_d  = refused_q;
    if (cfg_wr) begin
      if (bad_wr) begin
        refused_d = 1'b1;
      end else begin
        sel_src_d  = cfg_src;
        main_off_d = cfg_main_off;
        refused_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_src_q  <= SRC_MAIN;
      main_off_q <= 1'b0;
      refused_q  <= 1'b0;
    end else if (cfg_wr) begin
      sel_src_q  <= sel_src_d;
      main_off_q <= main_off_d;
      refused_q  <= refused_d;
    end
  end

  assign sel_src     = sel_src_q;
  assign main_sw_off = main_off_q;
  assign refused     = refused_q;

  // R10
  sub_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_src == SRC_SUB && !sub_osc_on) |=> (refused_q && $stable(sel_src_q)));

  // R11
  main_off_only_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    main_off_q |-> (sel_src_q == SRC_SUB));
endmodule

// File: rtl/ckg_gear.sv
module ckg_gear
  import ckg_pkg::*;
#(
  parameter int MAX_DIV = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  ckg_src_e sel_src,
  input  logic     main_run,
  input  logic     sub_tick,
  input  logic     sub_osc_on,
  output ckg_src_e act_src,
  output logic     pend,
  output logic     base_tick
);
  localparam int PH_W = $clog2(MAX_DIV);

  logic [PH_W-1:0] ph_q, ph_d;
  ckg_src_e        act_q, act_d;
  logic            old_alive;
  logic [3:0]      src_tick;

  always_comb begin
    ph_d = ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ph_q <= '0;
    else if (main_run) ph_q <= ph_d;
  end

  // One tick decoder per main-derived gear, divider 1 << g
  for (genvar g = 0; g < 3; g++) begin : g_gear
    localparam int DIV = 1 << g;
    always_comb begin
      src_tick[g] = main_run && ((ph_q & PH_W'(DIV - 1)) == PH_W'(DIV - 1));
    end
  end
  always_comb src_tick[3] = sub_tick && sub_osc_on;

  always_comb begin
    base_tick = src_tick[act_q];
    old_alive = (act_q == SRC_SUB) ? sub_osc_on : main_run;
    pend      = (sel_src != act_q);
    act_d     = act_q;
    if (pend && (base_tick || !old_alive)) act_d = sel_src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= SRC_MAIN;
    else        act_q <= act_d;
  end

  assign act_src = act_q;

  // R2
  switch_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_q) |-> ($past(base_tick) || !$past(old_alive)));

  // R1
  quarter_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q == SRC_DIV4 && base_tick && !pend) |=> !base_tick);
endmodule

// File: rtl/ckg_standby.sv
module ckg_standby
  import ckg_pkg::*;
#(
  parameter int SETTLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stby_req,
  input  ckg_mode_e           stby_mode,
  input  logic                wake,
  input  logic [SETTLE_W-1:0] settle_val,
  output ckg_pstate_e         pstate
);
  ckg_pstate_e         st_q, st_d;
  logic [SETTLE_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      PS_RUN: begin
        if (stby_req) begin
          unique case (stby_mode)
            MD_HALT:  st_d = PS_HALT;
            MD_QSTOP: st_d = PS_QSTOP;
            MD_STOP:  st_d = PS_STOP;
            default:  st_d = PS_RUN;
          endcase
        end
      end
      PS_HALT, PS_QSTOP: if (wake) st_d = PS_RUN;
      PS_STOP: begin
        if (wake) begin
          st_d  = PS_SETTLE;
          cnt_d = settle_val;
        end
      end
      PS_SETTLE: begin
        if (cnt_q == '0) st_d = PS_RUN;
        else             cnt_d = cnt_q - 1'b1;
      end
      default: st_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PS_RUN;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign pstate = st_q;

  // R7
  settle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_SETTLE && cnt_q != '0) |=> (st_q == PS_SETTLE && cnt_q == $past(cnt_q) - 1'b1));

  // R6
  light_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == PS_HALT || st_q == PS_QSTOP) && wake) |=> (st_q == PS_RUN));
endmodule

// File: rtl/ckgear_standby.sv
module ckgear_standby
  import ckg_pkg::*;
#(
  parameter int SETTLE_W = 16,
  parameter int MAX_DIV  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sub_tick,
  input  logic                sub_osc_on,
  input  logic                cfg_wr,
  input  logic [1:0]          cfg_src,
  input  logic                cfg_main_off,
  input  logic                stby_req,
  input  logic [1:0]          stby_mode,
  input  logic                irq_pend,
  input  logic                nmi,
  input  logic [SETTLE_W-1:0] settle_val,
  output logic                cpu_clk_en,
  output logic                per_clk_en,
  output logic                main_osc_en,
  output logic [7:0]          status
);
  ckg_src_e    sel_src, act_src;
  ckg_pstate_e pstate;
  logic        main_sw_off, refused, pend, base_tick;
  logic        main_run, per_run, wake;

  ckg_cfg i_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_src(ckg_src_e'(cfg_src)),
    .cfg_main_off(cfg_main_off), .sub_osc_on(sub_osc_on),
    .sel_src(sel_src), .main_sw_off(main_sw_off), .refused(refused)
  );

  ckg_standby #(.SETTLE_W(SETTLE_W)) i_stby (
    .clk(clk), .rst_n(rst_n), .stby_req(stby_req), .stby_mode(ckg_mode_e'(stby_mode)),
    .wake(wake), .settle_val(settle_val), .pstate(pstate)
  );

  ckg_gear #(.MAX_DIV(MAX_DIV)) i_gear (
    .clk(clk), .rst_n(rst_n), .sel_src(sel_src), .main_run(main_run),
    .sub_tick(sub_tick), .sub_osc_on(sub_osc_on),
    .act_src(act_src), .pend(pend), .base_tick(base_tick)
  );

  always_comb begin
    wake        = irq_pend || nmi;
    main_osc_en = (pstate != PS_STOP) && !main_sw_off;
    main_run    = main_osc_en && (pstate != PS_SETTLE);
    per_run     = (pstate == PS_RUN) || (pstate == PS_HALT);
    cpu_clk_en  = base_tick && (pstate == PS_RUN);
    per_clk_en  = per_run && (main_run || (sub_tick && sub_osc_on));
    status      = {pend, main_sw_off, refused, act_src, pstate};
  end

  // R3
  halt_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == PS_HALT) |-> (!cpu_clk_en && main_osc_en));

  // R5
  stop_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == PS_STOP) |-> (!main_osc_en && !per_clk_en && !cpu_clk_en));

  // R4
  qstop_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == PS_QSTOP) |-> (!per_clk_en && !cpu_clk_en && main_osc_en));
endmodule

// File: tb/test_ckgear_standby.sv
module test_ckgear_standby;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sub_tick, sub_osc_on, sub_gen;
  logic        cfg_wr, cfg_main_off, stby_req, irq_pend, nmi;
  logic [1:0]  cfg_src, stby_mode;
  logic [15:0] settle_val;
  logic        cpu_clk_en, per_clk_en, main_osc_en;
  logic [7:0]  status;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  ckgear_standby i_ckgear_standby (
    .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .sub_osc_on(sub_osc_on),
    .cfg_wr(cfg_wr), .cfg_src(cfg_src), .cfg_main_off(cfg_main_off),
    .stby_req(stby_req), .stby_mode(stby_mode), .irq_pend(irq_pend), .nmi(nmi),
    .settle_val(settle_val), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .main_osc_en(main_osc_en), .status(status)
  );

  // sub clock model: one pulse every 8 cycles while the oscillator runs
  initial begin
    int ph = 0;
    sub_tick = 1'b0;
    forever begin
      @(negedge clk);
      ph = (ph + 1) % 8;
      sub_tick = sub_gen && sub_osc_on && (ph == 0);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_en(input int n, output int c_cpu, output int c_per);
    c_cpu = 0; c_per = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      if (cpu_clk_en) c_cpu++;
      if (per_clk_en) c_per++;
    end
  endtask

  task automatic wr_cfg(input logic [1:0] src, input logic moff);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_src = src; cfg_main_off = moff;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_main_off = 1'b0;
  endtask

  task automatic standby(input logic [1:0] md);
    @(negedge clk);
    stby_req = 1'b1; stby_mode = md;
    @(negedge clk);
    stby_req = 1'b0;
  endtask

  task automatic pulse_wake(input bit use_nmi);
    @(negedge clk);
    if (use_nmi) nmi = 1'b1; else irq_pend = 1'b1;
    @(negedge clk);
    nmi = 1'b0; irq_pend = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    chk(status == 8'h00, "R9 reset status", status, 0);
    chk(main_osc_en && per_clk_en, "R9 reset enables", {main_osc_en, per_clk_en}, 3);
  endtask

  task automatic t_rates;
    int c, p;
    count_en(40, c, p);
    chk(c == 40, "R1 main rate", c, 40);
    wr_cfg(2'b01, 1'b0); cyc(8);
    count_en(40, c, p);
    chk(c == 20, "R1 half rate", c, 20);
    chk(status[4:3] == 2'b01, "R1 source field", status[4:3], 1);
    wr_cfg(2'b10, 1'b0); cyc(8);
    count_en(40, c, p);
    chk(c == 10, "R1 quarter rate", c, 10);
    wr_cfg(2'b11, 1'b0);
    #1;
    chk(status[7] == 1'b1, "R2 switch pending", status[7], 1);
    cyc(16);
    chk(status[7] == 1'b0, "R2 switch done", status[7], 0);
    count_en(40, c, p);
    chk(c == 5, "R1 sub rate", c, 5);
    wr_cfg(2'b00, 1'b0); cyc(16);
  endtask

  task automatic t_halt;
    int c, p;
    standby(2'b01); cyc(1);
    chk(status[2:0] == 3'd1, "R3 halt state", status[2:0], 1);
    count_en(16, c, p);
    chk(c == 0 && p == 16, "R3 halt enables", c * 100 + p, 16);
    chk(main_osc_en == 1'b1, "R3 osc on", main_osc_en, 1);
    pulse_wake(1'b0); #1;
    chk(status[2:0] == 3'd0, "R6 halt wake by irq", status[2:0], 0);
    count_en(8, c, p);
    chk(c == 8, "R6 cpu resumes", c, 8);
  endtask

  task automatic t_qstop;
    int c, p;
    standby(2'b10); cyc(1);
    count_en(16, c, p);
    chk(c == 0 && p == 0, "R4 qstop enables", c * 100 + p, 0);
    chk(main_osc_en && status[2:0] == 3'd2, "R4 qstop osc", {main_osc_en, status[2:0]}, 10);
    pulse_wake(1'b1); #1;
    chk(status[2:0] == 3'd0, "R8 qstop wake by nmi", status[2:0], 0);
  endtask

  task automatic t_stop;
    int c, p, n_set;
    settle_val = 16'd5;
    standby(2'b11); cyc(1); #1;
    chk(!main_osc_en && status[2:0] == 3'd3, "R5 stop", {main_osc_en, status[2:0]}, 3);
    count_en(8, c, p);
    chk(c == 0 && p == 0, "R5 stop enables", c * 100 + p, 0);
    @(negedge clk); nmi = 1'b1;
    @(negedge clk); nmi = 1'b0;
    n_set = 0;
    for (int i = 0; i < 20; i++) begin
      #1;
      if (status[2:0] == 3'd4) begin
        n_set++;
        if (cpu_clk_en || per_clk_en || !main_osc_en) chk(1'b0, "R7 settle outputs", 0, 1);
      end
      @(negedge clk);
    end
    chk(n_set == 6, "R7 settle length", n_set, 6);
    chk(status[2:0] == 3'd0, "R7 back to run", status[2:0], 0);
  endtask

  task automatic t_mode_none;
    standby(2'b00); cyc(2); #1;
    chk(status[2:0] == 3'd0, "R8 mode 00 ignored", status[2:0], 0);
  endtask

  task automatic t_main_off;
    int c, p;
    wr_cfg(2'b11, 1'b1); cyc(16); #1;
    chk(!main_osc_en && status[6], "R11 main off on sub", {main_osc_en, status[6]}, 1);
    count_en(40, c, p);
    chk(p == 5 && c == 5, "R11 per follows sub", p * 100 + c, 505);
    wr_cfg(2'b01, 1'b1); cyc(2); #1;
    chk(status[5] && status[4:3] == 2'b11 && status[6], "R11 main off refused",
        status, 8'h78);
    wr_cfg(2'b00, 1'b0); cyc(16); #1;
    chk(main_osc_en && !status[5] && status[4:3] == 2'b00, "R11 restart main", status, 0);
  endtask

  task automatic t_sub_refused;
    sub_osc_on = 1'b0;
    wr_cfg(2'b11, 1'b0); cyc(4); #1;
    chk(status[5] && status[4:3] == 2'b00 && !status[7], "R10 sub refused", status, 8'h20);
    sub_osc_on = 1'b1;
    wr_cfg(2'b01, 1'b0); cyc(4); #1;
    chk(!status[5], "R10 flag cleared", status[5], 0);
  endtask

  task automatic t_reset_restore;
    int c, p;
    wr_cfg(2'b10, 1'b0); cyc(8);
    @(negedge clk); rst_n = 1'b0;
    cyc(2); #1;
    chk(status == 8'h00, "R9 reset mid-run", status, 0);
    @(negedge clk); rst_n = 1'b1;
    count_en(40, c, p);
    chk(c == 40, "R9 full rate after reset", c, 40);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sub_osc_on = 1'b1; sub_gen = 1'b1;
    cfg_wr = 1'b0; cfg_src = 2'b00; cfg_main_off = 1'b0;
    stby_req = 1'b0; stby_mode = 2'b00; irq_pend = 1'b0; nmi = 1'b0;
    settle_val = 16'd0;
    cyc(3);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    cyc(2);
    t_rates();
    t_halt();
    t_qstop();
    t_stop();
    t_mode_none();
    t_main_off();
    t_sub_refused();
    t_reset_restore();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule